// File: doc/BRIEF.md
# Two-channel DMA control and status registers

This block is the software-visible register front of a DMA engine with two channels: one channel feeds a disk controller, the other a network controller. A 32-bit word bus slave reaches eight registers. Each channel has a control word holding an interrupt-pending flag, an interrupt enable, a peripheral reset command and a transfer direction. The top four bits of each control word always read as a fixed version code.

The disk channel keeps a running address counter. It advances by the byte length of each completed transfer. Writing that counter marks the channel as loaded. The disk peripheral can raise or drop its interrupt through dedicated request pins. For the network channel, the block forms the outgoing bus address by OR-ing the offset supplied by the peripheral with a base register. Commands written to the control words produce single-cycle reset pulses to the matching peripheral. The data movement itself happens outside this block.

Top module: `dma_csr_unit`

## Requirements
- R1: After reset, registers 0 and 4 read 0xA0000000, registers 1, 2, 3, 5, 6 and 7 read zero, and disk_irq, net_irq, disk_rst_pulse and net_rst_pulse are low.
- R2: The register index is bus_addr[4:2], and all other address bits are ignored. A read returns the stored value in the same cycle with bus_ready high whenever bus_sel is high, and a read changes nothing. Registers 1, 2, 3, 5, 6 and 7 store the full written word.
- R3: A write to register 0 or 4 stores bits [27:0] of the written value, with bits [31:28] forced to 0xA.
- R4: A register 0 write whose value has bit 7 clear is modified before it is stored. If bit 6 is set, bit 6 is stored as 0. If the whole value is zero, bit 6 is stored as 1. A value with bit 7 set is stored unmodified, apart from R3.
- R5: A write with bit 7 set drives a one-cycle high pulse in the following cycle. Register 0 drives it on disk_rst_pulse, and register 4 drives it on net_rst_pulse.
- R6: Writing register 0 with bit 4 (enable) clear drops disk_irq in the next cycle. Writing register 4 the same way drops net_irq. Writing with bit 4 set leaves the interrupt output unchanged.
- R7: Any write to register 1 sets bit 26 (loaded) of register 0.
- R8: A disk_done_valid pulse with length N adds N to register 1, modulo 2^32. It also sets bit 0 of register 0 and leaves disk_irq unchanged.
- R9: disk_irq_raise sets bit 0 of register 0 and asserts disk_irq. disk_irq_clear clears both.
- R10: net_irq_raise asserts net_irq and net_irq_clear deasserts it. Neither one changes register 4.
- R11: net_bus_addr equals net_offset OR register 7, combinationally.
- R12: disk_addr presents register 1, and disk_dir presents register 0 bit 8 (1 = device to memory).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the selected register |
| bus_ready | output | 1 | Access acknowledge, same cycle |
| disk_done_valid | input | 1 | Disk transfer completed |
| disk_done_len | input | LEN_W | Byte length of the completed disk transfer |
| disk_irq_raise | input | 1 | Disk peripheral interrupt request |
| disk_irq_clear | input | 1 | Disk peripheral interrupt withdraw |
| net_irq_raise | input | 1 | Network peripheral interrupt request |
| net_irq_clear | input | 1 | Network peripheral interrupt withdraw |
| net_offset | input | 32 | Network peripheral address offset |
| net_bus_addr | output | 32 | Network transfer bus address |
| disk_addr | output | 32 | Current disk transfer address |
| disk_dir | output | 1 | Disk direction, 1 = device to memory |
| disk_irq | output | 1 | Disk channel interrupt |
| net_irq | output | 1 | Network channel interrupt |
| disk_rst_pulse | output | 1 | Disk peripheral reset pulse |
| net_rst_pulse | output | 1 | Network peripheral reset pulse |

## Verification
The bench builds the block with its default parameters, ADDR_W = 8 and LEN_W = 16. With an 8-bit address, every one of the 64 word addresses in the space can be visited. Each register is therefore written through one alias and read back through another. The 16-bit length lets the largest transfer length, 65535, be applied, and a start near 2^32 exercises the address counter's wrap.

The control word fixup is swept over zero, every single-bit value and several combined values, for both channel control registers. The expected stored value and the reset pulse are computed from the rules in R3 to R5.

// File: rtl/dma_csr_pkg.sv
// Shared constants for the DMA control register unit.
// Assumes 32-bit registers and eight register slots.
package dma_csr_pkg;
    localparam int REG_W    = 32;
    localparam int NUM_REGS = 8;
    localparam int IDX_W    = $clog2(NUM_REGS);

    localparam logic [3:0] VER_CODE = 4'hA;

    localparam int B_PEND   = 0;
    localparam int B_EN     = 4;
    localparam int B_IDLE   = 6;
    localparam int B_RST    = 7;
    localparam int B_DIR    = 8;
    localparam int B_LOADED = 26;

    localparam logic [IDX_W-1:0] IDX_DCTRL = 3'd0;
    localparam logic [IDX_W-1:0] IDX_DADDR = 3'd1;
    localparam logic [IDX_W-1:0] IDX_NCTRL = 3'd4;
    localparam logic [IDX_W-1:0] IDX_NBASE = 3'd7;

    typedef logic [REG_W-1:0] word_t;
endpackage

// File: rtl/dma_csr_chan_ctrl.sv
// One channel control word with its interrupt output and reset pulse.
// The DISK_FIXUP parameter enables the bit-6 rewrite used only by the disk channel.
// Assumes at most one of wr_en / pend events per cycle in normal use; when they
// coincide, the written value is taken first, then loaded, then clear, then set.
module dma_csr_chan_ctrl
    import dma_csr_pkg::*;
#(
    parameter bit DISK_FIXUP = 1'b1
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  word_t wdata,
    input  logic  set_loaded,
    input  logic  pend_set,
    input  logic  pend_clr,
    input  logic  irq_raise,
    input  logic  irq_clear,
    output word_t ctrl_q,
    output logic  irq,
    output logic  rst_pulse
);
    word_t fixed_w;
    word_t next_w;

    // Rewrite the written value: bit-6 rule (disk only) and version nibble.
    always_comb begin
        fixed_w = wdata;
        if (DISK_FIXUP && !wdata[B_RST]) begin
            if (wdata[B_IDLE])
                fixed_w[B_IDLE] = 1'b0;
            else if (wdata == '0)
                fixed_w[B_IDLE] = 1'b1;
        end
        fixed_w[REG_W-1 -: 4] = VER_CODE;
    end

    // Merge the bus write with the status events into the next control word.
    always_comb begin
        next_w = wr_en ? fixed_w : ctrl_q;
        if (set_loaded) next_w[B_LOADED] = 1'b1;
        if (pend_clr)   next_w[B_PEND]   = 1'b0;
        if (pend_set)   next_w[B_PEND]   = 1'b1;
    end

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= {VER_CODE, {(REG_W-4){1'b0}}};
        else        ctrl_q <= next_w;
    end

    // Interrupt line: withdraw or disable wins over a raise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq <= 1'b0;
        else if (irq_clear || (wr_en && !wdata[B_EN]))
            irq <= 1'b0;
        else if (irq_raise)
            irq <= 1'b1;
    end

    // Peripheral reset pulse, one cycle after the commanding write.
    always_ff @(posedge clk) begin
        if (!rst_n) rst_pulse <= 1'b0;
        else        rst_pulse <= wr_en && wdata[B_RST];
    end
endmodule

// File: rtl/dma_csr_addr_ctr.sv
// Disk-channel address counter: loaded by the bus, advanced by completed length.
// A bus write takes priority over an advance in the same cycle.
module dma_csr_addr_ctr
    import dma_csr_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  word_t            wdata,
    input  logic             adv_en,
    input  logic [LEN_W-1:0] adv_len,
    output word_t            addr_q
);
    localparam int PAD_W = REG_W - LEN_W;

    // Load or advance the running address.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (wr_en)  addr_q <= wdata;
        else if (adv_en) addr_q <= addr_q + {{PAD_W{1'b0}}, adv_len};
    end
endmodule

// File: rtl/dma_csr_net_addr.sv
// Network-channel bus address former: peripheral offset OR base register.
module dma_csr_net_addr
    import dma_csr_pkg::*;
(
    input  word_t offset,
    input  word_t base,
    output word_t bus_addr
);
    // Combine offset and base bitwise.
    always_comb bus_addr = offset | base;
endmodule

// File: rtl/dma_csr_unit.sv
// Top of the two-channel DMA control register unit.
// Decodes a single-cycle word bus, holds eight registers (two control words,
// the disk address counter, five plain words) and drives per-channel interrupt
// and reset outputs. Assumes ADDR_W >= 6; address bits outside [4:2] alias.
module dma_csr_unit
    import dma_csr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    output logic              bus_ready,
    input  logic              disk_done_valid,
    input  logic [LEN_W-1:0]  disk_done_len,
    input  logic              disk_irq_raise,
    input  logic              disk_irq_clear,
    input  logic              net_irq_raise,
    input  logic              net_irq_clear,
    input  logic [REG_W-1:0]  net_offset,
    output logic [REG_W-1:0]  net_bus_addr,
    output logic [REG_W-1:0]  disk_addr,
    output logic              disk_dir,
    output logic              disk_irq,
    output logic              net_irq,
    output logic              disk_rst_pulse,
    output logic              net_rst_pulse
);
    logic [IDX_W-1:0]    reg_idx;
    logic                wr_any;
    logic [NUM_REGS-1:0] wr_hit;
    word_t               plain_q [NUM_REGS];
    word_t               dctrl_q;
    word_t               nctrl_q;
    word_t               daddr_q;
    logic                unused_addr_bits;

    assign reg_idx          = bus_addr[IDX_W+1:2];
    assign unused_addr_bits = ^{bus_addr[ADDR_W-1:IDX_W+2], bus_addr[1:0]};
    assign wr_any           = bus_sel && bus_wr;
    assign bus_ready        = bus_sel;

    // One-hot write strobe per register slot.
    always_comb begin
        wr_hit = '0;
        if (wr_any) wr_hit[reg_idx] = 1'b1;
    end

    // Plain storage registers; slots owned by other logic read as zero here.
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_plain
        if (g == int'(IDX_DCTRL) || g == int'(IDX_DADDR) || g == int'(IDX_NCTRL)) begin : g_none
            assign plain_q[g] = '0;
        end else begin : g_reg
            // Hold the full written word.
            always_ff @(posedge clk) begin
                if (!rst_n)         plain_q[g] <= '0;
                else if (wr_hit[g]) plain_q[g] <= bus_wdata;
            end
        end
    end

    dma_csr_chan_ctrl #(.DISK_FIXUP(1'b1)) u_disk_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_hit[IDX_DCTRL]),
        .wdata      (bus_wdata),
        .set_loaded (wr_hit[IDX_DADDR]),
        .pend_set   (disk_irq_raise || disk_done_valid),
        .pend_clr   (disk_irq_clear),
        .irq_raise  (disk_irq_raise),
        .irq_clear  (disk_irq_clear),
        .ctrl_q     (dctrl_q),
        .irq        (disk_irq),
        .rst_pulse  (disk_rst_pulse)
    );

    dma_csr_chan_ctrl #(.DISK_FIXUP(1'b0)) u_net_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_hit[IDX_NCTRL]),
        .wdata      (bus_wdata),
        .set_loaded (1'b0),
        .pend_set   (1'b0),
        .pend_clr   (1'b0),
        .irq_raise  (net_irq_raise),
        .irq_clear  (net_irq_clear),
        .ctrl_q     (nctrl_q),
        .irq        (net_irq),
        .rst_pulse  (net_rst_pulse)
    );

    dma_csr_addr_ctr #(.LEN_W(LEN_W)) u_disk_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_hit[IDX_DADDR]),
        .wdata   (bus_wdata),
        .adv_en  (disk_done_valid),
        .adv_len (disk_done_len),
        .addr_q  (daddr_q)
    );

    dma_csr_net_addr u_net_addr (
        .offset   (net_offset),
        .base     (plain_q[IDX_NBASE]),
        .bus_addr (net_bus_addr)
    );

    // Read data mux, free of side effects.
    always_comb begin
        case (reg_idx)
            IDX_DCTRL: bus_rdata = dctrl_q;
            IDX_DADDR: bus_rdata = daddr_q;
            IDX_NCTRL: bus_rdata = nctrl_q;
            default:   bus_rdata = plain_q[reg_idx];
        endcase
    end

    assign disk_addr = daddr_q;
    assign disk_dir  = dctrl_q[B_DIR];
endmodule

// File: rtl/dma_csr_chk.sv
// Property checker for dma_csr_unit, attached by bind.
module dma_csr_chk #(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              disk_done_valid,
    input logic [LEN_W-1:0]  disk_done_len,
    input logic              disk_irq_raise,
    input logic              disk_irq_clear,
    input logic [31:0]       disk_addr,
    input logic              disk_irq,
    input logic              disk_rst_pulse,
    input logic [31:0]       dctrl_q
);
    logic [2:0] idx;
    logic       wr_c0;
    logic       wr_a1;
    assign idx   = bus_addr[4:2];
    assign wr_c0 = bus_sel && bus_wr && idx == 3'd0;
    assign wr_a1 = bus_sel && bus_wr && idx == 3'd1;

    // R3
    ver_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && (idx == 3'd0 || idx == 3'd4)) |-> bus_rdata[31:28] == 4'hA);

    // R5
    disk_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disk_rst_pulse |-> $past(wr_c0 && bus_wdata[7]));

    // R5
    disk_rst_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c0 && bus_wdata[7]) |=> disk_rst_pulse);

    // R6
    irq_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_c0 && !bus_wdata[4]) |=> !disk_irq);

    // R7
    loaded_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a1 |=> dctrl_q[26]);

    // R8
    addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disk_done_valid && !wr_a1) |=>
        disk_addr == $past(disk_addr + {{(32-LEN_W){1'b0}}, disk_done_len}));

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disk_irq_raise && !disk_irq_clear && !(wr_c0 && !bus_wdata[4])) |=> (disk_irq && dctrl_q[0]));

    // R9
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disk_irq_clear && !disk_irq_raise && !disk_done_valid && !wr_c0) |=> (!disk_irq && !dctrl_q[0]));
endmodule

bind dma_csr_unit dma_csr_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dma_csr_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_sel         (bus_sel),
    .bus_wr          (bus_wr),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rdata       (bus_rdata),
    .disk_done_valid (disk_done_valid),
    .disk_done_len   (disk_done_len),
    .disk_irq_raise  (disk_irq_raise),
    .disk_irq_clear  (disk_irq_clear),
    .disk_addr       (disk_addr),
    .disk_irq        (disk_irq),
    .disk_rst_pulse  (disk_rst_pulse),
    .dctrl_q         (dctrl_q)
);

// File: tb/dma_csr_unit_bench.sv
// Self-checking bench for dma_csr_unit with default parameters.
module dma_csr_unit_bench;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_ready;
    logic              disk_done_valid = 1'b0;
    logic [LEN_W-1:0]  disk_done_len = '0;
    logic              disk_irq_raise = 1'b0;
    logic              disk_irq_clear = 1'b0;
    logic              net_irq_raise = 1'b0;
    logic              net_irq_clear = 1'b0;
    logic [31:0]       net_offset = '0;
    logic [31:0]       net_bus_addr;
    logic [31:0]       disk_addr;
    logic              disk_dir;
    logic              disk_irq;
    logic              net_irq;
    logic              disk_rst_pulse;
    logic              net_rst_pulse;

    int n_checks = 0;
    int n_errors = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    dma_csr_unit #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_dma_csr_unit (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .disk_done_valid(disk_done_valid),
        .disk_done_len(disk_done_len), .disk_irq_raise(disk_irq_raise),
        .disk_irq_clear(disk_irq_clear), .net_irq_raise(net_irq_raise),
        .net_irq_clear(net_irq_clear), .net_offset(net_offset),
        .net_bus_addr(net_bus_addr), .disk_addr(disk_addr), .disk_dir(disk_dir),
        .disk_irq(disk_irq), .net_irq(net_irq), .disk_rst_pulse(disk_rst_pulse),
        .net_rst_pulse(net_rst_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        check("R2 ready", {31'd0, bus_ready}, 32'd1);
        #1;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] disk_fix(input logic [31:0] v);
        logic [31:0] r = v;
        if (!v[7]) begin
            if (v[6]) r[6] = 1'b0;
            else if (v == 32'd0) r[6] = 1'b1;
        end
        return {4'hA, r[27:0]};
    endfunction

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                n_errors++;
                $display("FAIL watchdog: actual %0d expected below 100000", cycles);
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [31:0] rd;
        logic [31:0] rd2;
        logic [31:0] acc;
        logic [31:0] vals [37];

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int i = 0; i < 8; i++) begin
            bus_read(ADDR_W'(i * 4), rd);
            check("R1 reg", rd, (i == 0 || i == 4) ? 32'hA000_0000 : 32'd0);
        end
        check("R1 irq", {30'd0, disk_irq, net_irq}, 32'd0);
        check("R1 rst", {30'd0, disk_rst_pulse, net_rst_pulse}, 32'd0);

        // R2: write every word address, read back through a different alias
        for (int a = 0; a < 64; a++) begin
            if ((a % 8) != 0 && (a % 8) != 4) begin
                logic [31:0] pat = 32'h9E37_79B9 * (a + 1);
                bus_write(ADDR_W'(a * 4 + (a % 4)), pat);
                bus_read(ADDR_W'(((a + 8 * (1 + a % 7)) % 64) * 4), rd);
                check("R2 alias", rd, pat);
                bus_read(ADDR_W'(((a + 8 * (1 + a % 7)) % 64) * 4), rd2);
                check("R2 no side effect", rd2, pat);
            end
        end

        // R3 R4 R5: control word fixup sweep on both channels
        vals[0] = 32'd0;
        for (int i = 0; i < 32; i++) vals[i + 1] = 32'd1 << i;
        vals[33] = 32'h0000_00C0;
        vals[34] = 32'hFFFF_FFFF;
        vals[35] = 32'h1234_5678;
        vals[36] = 32'h5555_5540;
        for (int k = 0; k < 37; k++) begin
            bus_write(8'h00, vals[k]);
            check("R5 disk pulse", {31'd0, disk_rst_pulse}, {31'd0, vals[k][7]});
            check("R5 net quiet", {31'd0, net_rst_pulse}, 32'd0);
            bus_read(8'h00, rd);
            check("R4 disk ctrl", rd, disk_fix(vals[k]));
            check("R5 pulse ends", {31'd0, disk_rst_pulse}, 32'd0);
            bus_write(8'h10, vals[k]);
            check("R5 net pulse", {31'd0, net_rst_pulse}, {31'd0, vals[k][7]});
            bus_read(8'h10, rd);
            check("R3 net ctrl", rd, {4'hA, vals[k][27:0]});
        end

        // R7: loaded flag
        bus_write(8'h00, 32'h0000_0010);
        bus_write(8'h04, 32'h0000_1000);
        bus_read(8'h00, rd);
        check("R7 loaded", rd, 32'hA400_0010);

        // R8 R12: address advance, including wrap
        acc = 32'h0000_1000;
        for (int k = 0; k < 4; k++) begin
            logic [15:0] ln = (k == 0) ? 16'd1 : (k == 1) ? 16'd4 : (k == 2) ? 16'd255 : 16'hFFFF;
            @(negedge clk);
            disk_done_valid = 1'b1; disk_done_len = ln;
            @(negedge clk);
            disk_done_valid = 1'b0;
            acc = acc + {16'd0, ln};
            check("R12 disk_addr", disk_addr, acc);
            check("R8 no irq", {31'd0, disk_irq}, 32'd0);
        end
        bus_read(8'h04, rd);
        check("R8 reg1", rd, acc);
        bus_read(8'h00, rd);
        check("R8 pend", {31'd0, rd[0]}, 32'd1);
        bus_write(8'h24, 32'hFFFF_FFF0);
        @(negedge clk);
        disk_done_valid = 1'b1; disk_done_len = 16'h0020;
        @(negedge clk);
        disk_done_valid = 1'b0;
        check("R8 wrap", disk_addr, 32'h0000_0010);

        // R12: direction bit
        bus_write(8'h00, 32'h0000_0110);
        check("R12 dir set", {31'd0, disk_dir}, 32'd1);
        bus_write(8'h00, 32'h0000_0010);
        check("R12 dir clear", {31'd0, disk_dir}, 32'd0);

        // R9: raise and clear
        @(negedge clk); disk_irq_raise = 1'b1;
        @(negedge clk); disk_irq_raise = 1'b0;
        check("R9 raise irq", {31'd0, disk_irq}, 32'd1);
        bus_read(8'h00, rd);
        check("R9 raise pend", rd, 32'hA000_0011);
        @(negedge clk); disk_irq_clear = 1'b1;
        @(negedge clk); disk_irq_clear = 1'b0;
        check("R9 clear irq", {31'd0, disk_irq}, 32'd0);
        bus_read(8'h00, rd);
        check("R9 clear pend", rd, 32'hA000_0010);

        // R6: enable kept vs enable dropped, disk channel
        @(negedge clk); disk_irq_raise = 1'b1;
        @(negedge clk); disk_irq_raise = 1'b0;
        bus_write(8'h00, 32'h0000_0010);
        check("R6 disk kept", {31'd0, disk_irq}, 32'd1);
        bus_write(8'h00, 32'h0000_0000);
        check("R6 disk dropped", {31'd0, disk_irq}, 32'd0);
        bus_read(8'h00, rd);
        check("R4 zero write", rd, 32'hA000_0040);

        // R10 R6: network interrupt
        bus_write(8'h10, 32'h0000_0010);
        @(negedge clk); net_irq_raise = 1'b1;
        @(negedge clk); net_irq_raise = 1'b0;
        check("R10 net raise", {31'd0, net_irq}, 32'd1);
        bus_read(8'h10, rd);
        check("R10 reg4 untouched", rd, 32'hA000_0010);
        bus_write(8'h10, 32'h0000_0011);
        check("R6 net kept", {31'd0, net_irq}, 32'd1);
        bus_write(8'h10, 32'h0000_0001);
        check("R6 net dropped", {31'd0, net_irq}, 32'd0);
        @(negedge clk); net_irq_raise = 1'b1;
        @(negedge clk); net_irq_raise = 1'b0;
        @(negedge clk); net_irq_clear = 1'b1;
        @(negedge clk); net_irq_clear = 1'b0;
        check("R10 net clear", {31'd0, net_irq}, 32'd0);
        bus_read(8'h10, rd);
        check("R10 reg4 after clear", rd, 32'hA000_0001);

        // R11: network address former
        bus_write(8'h1C, 32'h00F0_0000);
        for (int i = 0; i < 34; i++) begin
            logic [31:0] off = (i < 32) ? (32'd1 << i) : (i == 32 ? 32'h0000_0000 : 32'h0F0F_F0F0);
            @(negedge clk);
            net_offset = off;
            #1;
            check("R11 net addr", net_bus_addr, off | 32'h00F0_0000);
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule